// File: doc/BRIEF.md
# Fixed-Frame Serial Link Receiver with Sequence Tracking

This block sits behind a byte-wide serial receiver and turns a raw byte stream into checked frames. It hunts for a run of four 0xAA bytes. It then captures a fixed-size frame made of a sequence number, a version word, a length word, a zero-padded data area and a CRC-32. Frames whose CRC matches are accepted. For data frames, the first `length` bytes of the data area are replayed on a byte-stream output, with markers on the first and last byte. Ping frames are accepted but produce no payload.

Every accepted frame also feeds a sequence tracker. The tracker compares the new sequence number with the previous one. It reports how many frames were skipped, and it recognises a drop back to zero as a restart of the peer. Single-cycle status pulses announce each outcome. Saturating counters accumulate good frames, CRC failures, lost frames and peer restarts. Input bytes may arrive with idle cycles between them. Because the payload is held in a two-bank buffer, frames may also arrive back to back.

Top module: `rxf_frame_receiver`

## Requirements
- R1: A frame begins after four consecutive accepted bytes equal to 0xAA. It then carries, in order: sequence number (4 bytes), version (2 bytes), length (2 bytes), DATA_BYTES data bytes, and CRC (4 bytes). Every multi-byte field arrives least-significant byte first. Cycles with `in_valid` low are ignored.
- R2: The CRC-32 starts at 0xFFFFFFFF and uses polynomial 0x04C11DB7. Each byte is shifted in most-significant bit first, with no reflection and no final inversion. It covers the sequence bytes, the length bytes and all data bytes, in arrival order. When the CRC matches, `ev_good` pulses in the cycle after the last CRC byte is accepted.
- R3: On a CRC mismatch, `ev_crc_err` pulses and `cnt_crc_err` increments. No payload is emitted and the sequence reference is left unchanged.
- R4: A header is rejected when its version is neither 0x0001 (DATA) nor 0x0002 (PING), or when its length exceeds DATA_BYTES. In that case `ev_bad_hdr` pulses once, the remaining bytes of that frame are skipped without delimiter search, and hunting resumes afterwards.
- R5: A good DATA frame emits its first `length` data bytes, one per cycle. Output starts in the same cycle as `ev_good`, with `out_first` on the first byte and `out_last` on the last byte. A length of 0 emits nothing.
- R6: A good PING frame pulses `ev_good` and updates the sequence reference, but emits no payload.
- R7: The first good frame after reset only sets the sequence reference. It raises neither `ev_lost` nor `ev_peer_reset`.
- R8: If the new sequence number is greater than the previous one plus 1, `ev_lost` pulses, `gap_lost` equals new − previous − 1, and `cnt_lost` grows by that amount.
- R9: A sequence number of 0 following a non-zero one pulses `ev_peer_reset` and increments `cnt_reset`. It never counts as a loss.
- R10: A sequence number equal to the previous one plus 1, or not above the previous one (except the restart case), raises no sequence event.
- R11: All four counters stop at their all-ones value of CNT_W bits.
- R12: `cnt_good` increments once per good frame, whether DATA or PING.
- R13: A frame that directly follows another, with no idle cycles between them, is received and its payload emitted correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A received byte is present |
| in_data | input | 8 | Received byte |
| out_valid | output | 1 | Payload byte valid |
| out_data | output | 8 | Payload byte |
| out_first | output | 1 | First payload byte of a frame |
| out_last | output | 1 | Last payload byte of a frame |
| ev_good | output | 1 | Pulse: frame accepted |
| ev_crc_err | output | 1 | Pulse: CRC mismatch |
| ev_bad_hdr | output | 1 | Pulse: header rejected |
| ev_lost | output | 1 | Pulse: sequence gap detected |
| ev_peer_reset | output | 1 | Pulse: sequence restarted at 0 |
| gap_lost | output | 32 | Frames missing in the last gap |
| cnt_good | output | CNT_W | Saturating good-frame count |
| cnt_crc_err | output | CNT_W | Saturating CRC-failure count |
| cnt_lost | output | CNT_W | Saturating lost-frame total |
| cnt_reset | output | CNT_W | Saturating peer-restart count |

## Verification
The bench builds the receiver with DATA_BYTES = 16 and CNT_W = 3. The 16-byte data area shrinks each frame to 32 bytes, so many scenarios fit in a short run, and a length of 17 exercises the oversize-length rejection. The 3-bit counters saturate at 7, so a single large sequence gap and a handful of corrupted frames are enough to drive the lost, CRC-failure and good counters into saturation and confirm they hold there.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;
  localparam logic [7:0]  DELIM    = 8'hAA;
  localparam logic [15:0] VER_DATA = 16'h0001;
  localparam logic [15:0] VER_PING = 16'h0002;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_HDR,
    ST_DATA,
    ST_CRC,
    ST_SKIP
  } rx_state_e;

  typedef enum logic [1:0] {
    SEQ_FIRST,
    SEQ_NEXT,
    SEQ_GAP,
    SEQ_ROLL
  } seq_kind_e;

  // one byte through the CRC register, bit 7 first
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[31] ^ b[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  function automatic seq_kind_e seq_classify(input logic have_ref,
                                             input logic [31:0] prev,
                                             input logic [31:0] cur);
    if (!have_ref) return SEQ_FIRST;
    if (cur == 32'd0 && prev != 32'd0) return SEQ_ROLL;
    if ({1'b0, cur} > ({1'b0, prev} + 33'd1)) return SEQ_GAP;
    return SEQ_NEXT;
  endfunction

  function automatic logic [31:0] seq_missing(input logic [31:0] prev, input logic [31:0] cur);
    return cur - prev - 32'd1;
  endfunction

endpackage

// File: rtl/rxf_crc32.sv
module rxf_crc32
  import rxf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= CRC_INIT;
    else if (clear) crc <= CRC_INIT;
    else if (en)    crc <= crc_step(crc, din);
  end

endmodule

// File: rtl/rxf_payload_buf.sv
module rxf_payload_buf #(
  parameter int DATA_BYTES = 256,
  parameter int IW         = 9
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_byte,
  input  logic          start,
  input  logic [15:0]   start_len,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_first,
  output logic          out_last
);

  localparam int AW = $clog2(2 * DATA_BYTES);
  localparam int PW = $clog2(DATA_BYTES + 1);

  logic [7:0]    mem [2*DATA_BYTES];
  logic          wr_bank, rd_bank, active;
  logic [PW-1:0] rd_idx, rd_len;

  function automatic logic [AW-1:0] bank_addr(input logic bank, input logic [AW-1:0] off);
    return (bank ? AW'(DATA_BYTES) : AW'(0)) + off;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[bank_addr(wr_bank, AW'(wr_idx))] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bank <= 1'b0;
      rd_bank <= 1'b0;
      active  <= 1'b0;
      rd_idx  <= '0;
      rd_len  <= '0;
    end else if (start) begin
      active  <= 1'b1;
      rd_bank <= wr_bank;
      wr_bank <= ~wr_bank;
      rd_idx  <= '0;
      rd_len  <= PW'(start_len);
    end else if (active) begin
      if (rd_idx == rd_len - PW'(1)) active <= 1'b0;
      else                           rd_idx <= rd_idx + PW'(1);
    end
  end

  assign out_valid = active;
  assign out_data  = mem[bank_addr(rd_bank, AW'(rd_idx))];
  assign out_first = active && (rd_idx == '0);
  assign out_last  = active && (rd_idx == rd_len - PW'(1));

endmodule

// File: rtl/rxf_seq_tracker.sv
module rxf_seq_tracker
  import rxf_pkg::*;
#(
  parameter int CNT_W = 32
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             good_stb,
  input  logic             crc_stb,
  input  logic [31:0]      seq_in,
  output seq_kind_e        seq_kind,
  output logic             ev_good,
  output logic             ev_crc_err,
  output logic             ev_lost,
  output logic             ev_peer_reset,
  output logic [31:0]      gap_lost,
  output logic [CNT_W-1:0] cnt_good,
  output logic [CNT_W-1:0] cnt_crc_err,
  output logic [CNT_W-1:0] cnt_lost,
  output logic [CNT_W-1:0] cnt_reset
);

  localparam int SUM_W = ((CNT_W > 32) ? CNT_W : 32) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a, input logic [31:0] inc);
    logic [SUM_W-1:0] sum;
    sum = SUM_W'(a) + SUM_W'(inc);
    if (sum > SUM_W'(CNT_MAX)) return CNT_MAX;
    return CNT_W'(sum);
  endfunction

  logic        have_ref;
  logic [31:0] prev_seq;
  logic [31:0] missing;

  assign seq_kind = seq_classify(have_ref, prev_seq, seq_in);
  assign missing  = seq_missing(prev_seq, seq_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_ref      <= 1'b0;
      prev_seq      <= '0;
      ev_good       <= 1'b0;
      ev_crc_err    <= 1'b0;
      ev_lost       <= 1'b0;
      ev_peer_reset <= 1'b0;
      gap_lost      <= '0;
      cnt_good      <= '0;
      cnt_crc_err   <= '0;
      cnt_lost      <= '0;
      cnt_reset     <= '0;
    end else begin
      ev_good       <= 1'b0;
      ev_crc_err    <= 1'b0;
      ev_lost       <= 1'b0;
      ev_peer_reset <= 1'b0;
      if (good_stb) begin
        ev_good  <= 1'b1;
        cnt_good <= sat_add(cnt_good, 32'd1);
        have_ref <= 1'b1;
        prev_seq <= seq_in;
        case (seq_kind)
          SEQ_GAP: begin
            ev_lost  <= 1'b1;
            gap_lost <= missing;
            cnt_lost <= sat_add(cnt_lost, missing);
          end
          SEQ_ROLL: begin
            ev_peer_reset <= 1'b1;
            cnt_reset     <= sat_add(cnt_reset, 32'd1);
          end
          default: ;
        endcase
      end
      if (crc_stb) begin
        ev_crc_err  <= 1'b1;
        cnt_crc_err <= sat_add(cnt_crc_err, 32'd1);
      end
    end
  end

endmodule

// File: rtl/rxf_frame_receiver.sv
module rxf_frame_receiver
  import rxf_pkg::*;
#(
  parameter int DATA_BYTES = 256,
  parameter int CNT_W      = 32
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_first,
  output logic             out_last,
  output logic             ev_good,
  output logic             ev_crc_err,
  output logic             ev_bad_hdr,
  output logic             ev_lost,
  output logic             ev_peer_reset,
  output logic [31:0]      gap_lost,
  output logic [CNT_W-1:0] cnt_good,
  output logic [CNT_W-1:0] cnt_crc_err,
  output logic [CNT_W-1:0] cnt_lost,
  output logic [CNT_W-1:0] cnt_reset
);

  localparam int IDX_W = $clog2(DATA_BYTES + 5);
  localparam logic [IDX_W-1:0] HDR_END  = IDX_W'(7);
  localparam logic [IDX_W-1:0] DATA_END = IDX_W'(DATA_BYTES - 1);
  localparam logic [IDX_W-1:0] CRC_END  = IDX_W'(3);
  localparam logic [IDX_W-1:0] SKIP_END = IDX_W'(DATA_BYTES + 3);
  localparam logic [15:0]      MAX_LEN  = 16'(DATA_BYTES);

  rx_state_e        st;
  logic [IDX_W-1:0] idx;
  logic [1:0]       aa_cnt;
  logic [31:0]      seq_r, crc_rx, crc_calc;
  logic [15:0]      ver_r, len_r;
  seq_kind_e        seq_kind;

  // named events between the framer, CRC, buffer and tracker
  logic        delim_hit, hdr_last, hdr_bad, frame_end, crc_match;
  logic        good_stb, crc_stb, play_start, crc_en, data_wr;
  logic [15:0] len_full;
  logic        ver_ok;

  assign delim_hit  = (st == ST_HUNT) && in_valid && (in_data == DELIM) && (aa_cnt == 2'd3);
  assign hdr_last   = (st == ST_HDR) && in_valid && (idx == HDR_END);
  assign len_full   = {in_data, len_r[15:8]};
  assign ver_ok     = (ver_r == VER_DATA) || (ver_r == VER_PING);
  assign hdr_bad    = hdr_last && (!ver_ok || (len_full > MAX_LEN));
  assign frame_end  = (st == ST_CRC) && in_valid && (idx == CRC_END);
  assign crc_match  = ({in_data, crc_rx[31:8]} == crc_calc);
  assign good_stb   = frame_end && crc_match;
  assign crc_stb    = frame_end && !crc_match;
  assign play_start = good_stb && (ver_r == VER_DATA) && (len_r != 16'd0);
  assign data_wr    = (st == ST_DATA) && in_valid;
  assign crc_en     = in_valid && ((st == ST_DATA) ||
                      ((st == ST_HDR) && ((idx < IDX_W'(4)) || (idx >= IDX_W'(6)))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_HUNT;
      idx        <= '0;
      aa_cnt     <= '0;
      seq_r      <= '0;
      ver_r      <= '0;
      len_r      <= '0;
      crc_rx     <= '0;
      ev_bad_hdr <= 1'b0;
    end else begin
      ev_bad_hdr <= hdr_bad;
      if (in_valid) begin
        unique case (st)
          ST_HUNT: begin
            if (in_data != DELIM) aa_cnt <= '0;
            else if (delim_hit) begin
              aa_cnt <= '0;
              idx    <= '0;
              st     <= ST_HDR;
            end else aa_cnt <= aa_cnt + 2'd1;
          end
          ST_HDR: begin
            if (idx < IDX_W'(4))      seq_r <= {in_data, seq_r[31:8]};
            else if (idx < IDX_W'(6)) ver_r <= {in_data, ver_r[15:8]};
            else                      len_r <= {in_data, len_r[15:8]};
            idx <= idx + IDX_W'(1);
            if (hdr_last) begin
              idx <= '0;
              st  <= hdr_bad ? ST_SKIP : ST_DATA;
            end
          end
          ST_DATA: begin
            idx <= idx + IDX_W'(1);
            if (idx == DATA_END) begin
              idx <= '0;
              st  <= ST_CRC;
            end
          end
          ST_CRC: begin
            crc_rx <= {in_data, crc_rx[31:8]};
            idx    <= idx + IDX_W'(1);
            if (frame_end) st <= ST_HUNT;
          end
          ST_SKIP: begin
            idx <= idx + IDX_W'(1);
            if (idx == SKIP_END) st <= ST_HUNT;
          end
          default: st <= ST_HUNT;
        endcase
      end
    end
  end

  rxf_crc32 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (delim_hit),
    .en    (crc_en),
    .din   (in_data),
    .crc   (crc_calc)
  );

  rxf_payload_buf #(.DATA_BYTES(DATA_BYTES), .IW(IDX_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (data_wr),
    .wr_idx    (idx),
    .wr_byte   (in_data),
    .start     (play_start),
    .start_len (len_r),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_first (out_first),
    .out_last  (out_last)
  );

  rxf_seq_tracker #(.CNT_W(CNT_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .good_stb      (good_stb),
    .crc_stb       (crc_stb),
    .seq_in        (seq_r),
    .seq_kind      (seq_kind),
    .ev_good       (ev_good),
    .ev_crc_err    (ev_crc_err),
    .ev_lost       (ev_lost),
    .ev_peer_reset (ev_peer_reset),
    .gap_lost      (gap_lost),
    .cnt_good      (cnt_good),
    .cnt_crc_err   (cnt_crc_err),
    .cnt_lost      (cnt_lost),
    .cnt_reset     (cnt_reset)
  );

endmodule

// File: rtl/rxf_checks.sv
module rxf_checks #(
  parameter int CNT_W = 32
)(
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_first,
  input logic             out_last,
  input logic             ev_good,
  input logic             ev_crc_err,
  input logic             ev_bad_hdr,
  input logic             ev_lost,
  input logic             ev_peer_reset,
  input logic [31:0]      gap_lost,
  input logic [CNT_W-1:0] cnt_good,
  input logic [CNT_W-1:0] cnt_crc_err,
  input logic [CNT_W-1:0] cnt_lost,
  input logic             play_start
);

  p_first_is_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid);

  p_payload_with_good_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> ev_good);

  p_run_closes_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |=> !out_valid);

  p_start_when_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    play_start |-> !out_valid);

  p_single_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_good, ev_crc_err, ev_bad_hdr}));

  p_crc_counted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_crc_err |-> (cnt_crc_err != '0));

  p_gap_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lost |-> (ev_good && gap_lost != 32'd0 && cnt_lost != '0));

  p_restart_not_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_peer_reset |-> (ev_good && !ev_lost));

  p_good_monotonic_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_good >= $past(cnt_good));

  p_lost_monotonic_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_lost >= $past(cnt_lost));

endmodule

bind rxf_frame_receiver rxf_checks #(.CNT_W(CNT_W)) u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .out_valid     (out_valid),
  .out_first     (out_first),
  .out_last      (out_last),
  .ev_good       (ev_good),
  .ev_crc_err    (ev_crc_err),
  .ev_bad_hdr    (ev_bad_hdr),
  .ev_lost       (ev_lost),
  .ev_peer_reset (ev_peer_reset),
  .gap_lost      (gap_lost),
  .cnt_good      (cnt_good),
  .cnt_crc_err   (cnt_crc_err),
  .cnt_lost      (cnt_lost),
  .play_start    (play_start)
);

// File: tb/rxf_frame_receiver_test.sv
`timescale 1ns/1ps
module rxf_frame_receiver_test;

  localparam int DB = 16;
  localparam int CW = 3;
  localparam int FR = DB + 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic          out_valid, out_first, out_last;
  logic [7:0]    out_data;
  logic          ev_good, ev_crc_err, ev_bad_hdr, ev_lost, ev_peer_reset;
  logic [31:0]   gap_lost;
  logic [CW-1:0] cnt_good, cnt_crc_err, cnt_lost, cnt_reset;

  always #2.5 clk = ~clk;

  rxf_frame_receiver #(.DATA_BYTES(DB), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_first(out_first), .out_last(out_last),
    .ev_good(ev_good), .ev_crc_err(ev_crc_err), .ev_bad_hdr(ev_bad_hdr),
    .ev_lost(ev_lost), .ev_peer_reset(ev_peer_reset), .gap_lost(gap_lost),
    .cnt_good(cnt_good), .cnt_crc_err(cnt_crc_err), .cnt_lost(cnt_lost), .cnt_reset(cnt_reset)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor, sampled away from the active edge
  int m_good, m_crc, m_bad, m_lost, m_rst, m_firsts, m_lasts, rx_n;
  int m_good_cyc, m_first_cyc, last_cyc;
  logic [31:0] m_gap;
  logic [7:0]  rx_buf [64];
  logic [7:0]  exp_buf [64];
  int          exp_n;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ev_good) begin m_good++; m_good_cyc = cyc; end
      if (ev_crc_err) m_crc++;
      if (ev_bad_hdr) m_bad++;
      if (ev_lost) begin m_lost++; m_gap = gap_lost; end
      if (ev_peer_reset) m_rst++;
      if (out_valid) begin
        if (out_first) begin m_firsts++; m_first_cyc = cyc; end
        if (out_last) m_lasts++;
        if (rx_n < 64) rx_buf[rx_n] = out_data;
        rx_n++;
      end
    end
  end

  task automatic clear_mon();
    m_good = 0; m_crc = 0; m_bad = 0; m_lost = 0; m_rst = 0;
    m_firsts = 0; m_lasts = 0; rx_n = 0; exp_n = 0; m_gap = '0;
    m_good_cyc = -1; m_first_cyc = -2;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tb_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {b, 24'h0};
    repeat (8) r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
    return r;
  endfunction

  task automatic put_byte(input logic [7:0] b, input int gap);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    last_cyc = cyc;
    if (gap > 0) begin
      in_valid = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // builds and sends one frame; expect_out appends its payload to the expectation
  task automatic send_frame(input logic [31:0] seq, input logic [15:0] ver, input logic [15:0] len,
                            input logic [7:0] seed, input bit all_aa, input bit bad_crc,
                            input bit expect_out, input int gap);
    logic [7:0]  fr [FR];
    logic [31:0] c;
    for (int i = 0; i < 4; i++) fr[i] = 8'hAA;
    for (int i = 0; i < 4; i++) fr[4+i] = seq[8*i +: 8];
    fr[8] = ver[7:0];  fr[9]  = ver[15:8];
    fr[10] = len[7:0]; fr[11] = len[15:8];
    for (int i = 0; i < DB; i++)
      fr[12+i] = all_aa ? 8'hAA : ((i < int'(len)) ? (seed ^ 8'(i * 7)) : 8'h00);
    c = 32'hFFFFFFFF;
    for (int i = 4; i < 8; i++) c = tb_crc(c, fr[i]);
    c = tb_crc(c, fr[10]);
    c = tb_crc(c, fr[11]);
    for (int i = 0; i < DB; i++) c = tb_crc(c, fr[12+i]);
    if (bad_crc) c = c ^ 32'h0000_0100;
    for (int i = 0; i < 4; i++) fr[12+DB+i] = c[8*i +: 8];
    if (expect_out)
      for (int i = 0; i < int'(len); i++) begin exp_buf[exp_n] = fr[12+i]; exp_n++; end
    for (int i = 0; i < FR; i++) put_byte(fr[i], gap);
    in_valid = 1'b0;
  endtask

  task automatic cmp_payload(input string req);
    chk(rx_n == exp_n, req, rx_n, exp_n);
    for (int i = 0; i < exp_n && i < rx_n; i++)
      chk(rx_buf[i] == exp_buf[i], req, rx_buf[i], exp_buf[i]);
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R5 reset out_valid", out_valid, 0);
    chk(cnt_good == '0, "R12 reset cnt_good", cnt_good, 0);
    chk(cnt_lost == '0 && cnt_crc_err == '0 && cnt_reset == '0, "R11 reset counters",
        cnt_lost + cnt_crc_err + cnt_reset, 0);
  endtask

  task automatic t_first_frame();
    clear_mon();
    put_byte(8'hAA, 0); put_byte(8'hAA, 0); put_byte(8'hAA, 0);
    put_byte(8'h55, 0); put_byte(8'h12, 0);
    send_frame(32'd5, 16'h0001, 16'd5, 8'h30, 1'b0, 1'b0, 1'b1, 0);
    idle(DB + 8);
    chk(m_good == 1, "R1 frame found after noise", m_good, 1);
    chk(m_good_cyc == last_cyc, "R2 ev_good timing", m_good_cyc, last_cyc);
    cmp_payload("R5 payload");
    chk(m_firsts == 1 && m_lasts == 1, "R5 markers", m_firsts * 10 + m_lasts, 11);
    chk(m_first_cyc == m_good_cyc, "R5 first byte cycle", m_first_cyc, m_good_cyc);
    chk(m_lost == 0 && m_rst == 0, "R7 no event on first", m_lost + m_rst, 0);
    chk(cnt_good == 3'd1, "R12 cnt_good", cnt_good, 1);
  endtask

  task automatic t_full_gappy();
    clear_mon();
    send_frame(32'd6, 16'h0001, 16'd16, 8'hA0, 1'b0, 1'b0, 1'b1, 2);
    idle(DB + 8);
    cmp_payload("R1 idle cycles between bytes");
    chk(m_good == 1 && m_lost == 0, "R10 next seq no event", m_lost, 0);
  endtask

  task automatic t_gap();
    clear_mon();
    send_frame(32'd10, 16'h0001, 16'd3, 8'h5C, 1'b0, 1'b0, 1'b1, 0);
    idle(DB + 8);
    chk(m_lost == 1, "R8 ev_lost", m_lost, 1);
    chk(m_gap == 32'd3, "R8 gap_lost", m_gap, 3);
    chk(cnt_lost == 3'd3, "R8 cnt_lost", cnt_lost, 3);
    cmp_payload("R8 payload");
  endtask

  task automatic t_ping();
    clear_mon();
    send_frame(32'd11, 16'h0002, 16'd4, 8'h01, 1'b0, 1'b0, 1'b0, 0);
    idle(DB + 8);
    chk(m_good == 1, "R6 ping accepted", m_good, 1);
    chk(rx_n == 0, "R6 ping no payload", rx_n, 0);
    clear_mon();
    send_frame(32'd12, 16'h0001, 16'd2, 8'h77, 1'b0, 1'b0, 1'b1, 0);
    idle(DB + 8);
    chk(m_lost == 0, "R6 ping updated sequence", m_lost, 0);
    cmp_payload("R6 data after ping");
  endtask

  task automatic t_crc_bad();
    clear_mon();
    send_frame(32'd13, 16'h0001, 16'd6, 8'h42, 1'b0, 1'b1, 1'b0, 0);
    idle(DB + 8);
    chk(m_crc == 1 && m_good == 0, "R3 ev_crc_err", m_crc, 1);
    chk(rx_n == 0, "R3 no payload", rx_n, 0);
    chk(cnt_crc_err == 3'd1, "R3 cnt_crc_err", cnt_crc_err, 1);
    clear_mon();
    send_frame(32'd14, 16'h0001, 16'd1, 8'h09, 1'b0, 1'b0, 1'b1, 0);
    idle(DB + 8);
    chk(m_lost == 1 && m_gap == 32'd1, "R3 reference unchanged", m_gap, 1);
  endtask

  task automatic t_bad_hdr();
    clear_mon();
    send_frame(32'd15, 16'h0003, 16'd2, 8'h00, 1'b1, 1'b0, 1'b0, 0);
    send_frame(32'd15, 16'h0001, 16'd1, 8'h3E, 1'b0, 1'b0, 1'b1, 0);
    idle(DB + 8);
    chk(m_bad == 1, "R4 bad version", m_bad, 1);
    chk(m_good == 1 && m_lost == 0, "R4 no resync inside", m_good, 1);
    cmp_payload("R4 following frame");
    clear_mon();
    send_frame(32'd16, 16'h0001, 16'd17, 8'h00, 1'b1, 1'b0, 1'b0, 0);
    send_frame(32'd16, 16'h0001, 16'd4, 8'h61, 1'b0, 1'b0, 1'b1, 0);
    idle(DB + 8);
    chk(m_bad == 1 && m_good == 1, "R4 oversize length", m_bad * 10 + m_good, 11);
    cmp_payload("R4 after oversize");
  endtask

  task automatic t_len0();
    clear_mon();
    send_frame(32'd17, 16'h0001, 16'd0, 8'h00, 1'b0, 1'b0, 1'b0, 0);
    idle(DB + 8);
    chk(m_good == 1 && rx_n == 0, "R5 zero length", rx_n, 0);
  endtask

  task automatic t_peer_reset();
    clear_mon();
    send_frame(32'd0, 16'h0001, 16'd2, 8'h10, 1'b0, 1'b0, 1'b1, 0);
    idle(DB + 8);
    chk(m_rst == 1 && m_lost == 0, "R9 restart", m_rst * 10 + m_lost, 10);
    chk(cnt_reset == 3'd1, "R9 cnt_reset", cnt_reset, 1);
    clear_mon();
    send_frame(32'd0, 16'h0001, 16'd2, 8'h11, 1'b0, 1'b0, 1'b1, 0);
    idle(DB + 8);
    chk(m_rst == 0 && m_lost == 0 && m_good == 1, "R10 repeated zero", m_rst + m_lost, 0);
  endtask

  task automatic t_back_to_back();
    clear_mon();
    send_frame(32'd1, 16'h0001, 16'd16, 8'h0B, 1'b0, 1'b0, 1'b1, 0);
    send_frame(32'd2, 16'h0001, 16'd7, 8'h4D, 1'b0, 1'b0, 1'b1, 0);
    idle(DB + 8);
    chk(m_good == 2 && m_firsts == 2 && m_lasts == 2, "R13 two frames", m_good, 2);
    cmp_payload("R13 payloads");
  endtask

  task automatic t_saturate();
    clear_mon();
    send_frame(32'd1000, 16'h0001, 16'd1, 8'h21, 1'b0, 1'b0, 1'b1, 0);
    idle(DB + 8);
    chk(m_gap == 32'd997, "R8 large gap", m_gap, 997);
    chk(cnt_lost == 3'd7, "R11 cnt_lost saturates", cnt_lost, 7);
    for (int k = 0; k < 7; k++) send_frame(32'd1001, 16'h0001, 16'd1, 8'h00, 1'b0, 1'b1, 1'b0, 0);
    idle(DB + 8);
    chk(cnt_crc_err == 3'd7, "R11 cnt_crc_err saturates", cnt_crc_err, 7);
    chk(cnt_good == 3'd7, "R12 cnt_good saturates", cnt_good, 7);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_frame();
    t_full_gappy();
    t_gap();
    t_ping();
    t_crc_bad();
    t_bad_hdr();
    t_len0();
    t_peer_reset();
    t_back_to_back();
    t_saturate();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule